// File: doc/BRIEF.md
# Almost-Flag Offset Loader

This block fills the four threshold registers used by the almost-empty and almost-full comparators of a pair of opposite-direction FIFOs. There is one almost-empty and one almost-full threshold for each port side. The method of filling is captured while master reset is held low. Three methods exist. The first is a fixed preset, with the choice of 8, 16 or 64 in every register. The second loads the four registers one after another from enabled port-A bus writes. The third shifts the values in bit by bit on the port-A clock. In serial mode the two select pins become a serial enable and a serial data line.

The FIFOs must not run until every threshold holds its value, so the block gates two ready signals. The port-B input-ready signal stays low until loading has finished, and from then on it stays high. The port-A input-ready signal is low during a serial load. During a parallel load it is high, because the port-A writes are then taken by the loader. After loading has finished it is always high. The comparators and the FIFO storage sit outside this block.

Top module: `ofs_loader`

## Requirements
- R1: While `mrst_n` is low at a rising clock edge, that edge clears `b_in_rdy` and `a_in_rdy` and restarts loading. The offsets take the preset value in a preset mode and 0 in any other mode. A reset in the middle of a load discards the partial load.
- R2: At each rising edge with `mrst_n` low, the mode is taken from the pins. `cfg_serial`=1 selects serial mode. Otherwise `{cfg_sel_hi,cfg_sel_lo}` selects the mode: 00 parallel, 01 preset 8, 10 preset 16, 11 preset 64. The value captured at the last reset edge stays in force until the next reset.
- R3: In a preset mode, all four offsets hold the preset value. `b_in_rdy` rises at the first rising edge after `mrst_n` goes high.
- R4: In parallel mode, each edge with `a_wr`=1 writes `a_data[OFS_W-1:0]` into the next register, with bit OFS_W-1 as the MSB. The order is ae_a, ae_b, af_a, af_b. Bits above OFS_W-1 are ignored.
- R5: In parallel mode, edges with `a_wr`=0 change nothing. `b_in_rdy` rises at the edge that takes the fourth write.
- R6: In serial mode, each edge with `cfg_sel_hi`=1 shifts `cfg_sel_lo` into the LSB of the 4*OFS_W-bit chain {ae_a, ae_b, af_a, af_b}, so the data arrives MSB first. Edges with `cfg_sel_hi`=0 leave the chain unchanged. `b_in_rdy` rises at the edge of the 4*OFS_W-th shift.
- R7: Outside reset, `a_in_rdy` is low while a serial load is still incomplete. It is high from the first edge after reset during a parallel load, and high whenever `b_in_rdy` is high.
- R8: Once `b_in_rdy` is high, it stays high and the four offsets stay unchanged until the next reset, whatever happens on `a_wr`, `a_data` or the select pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port-A clock |
| mrst_n | input | 1 | Master reset, active low, sampled on the clock |
| cfg_serial | input | 1 | Serial mode select, sampled during reset |
| cfg_sel_hi | input | 1 | Mode select bit during reset; serial enable afterwards |
| cfg_sel_lo | input | 1 | Mode select bit during reset; serial data afterwards |
| a_wr | input | 1 | Enabled port-A write strobe |
| a_data | input | A_W (36) | Port-A write data |
| ofs_ae_a | output | OFS_W (8) | Almost-empty threshold, port-A side |
| ofs_ae_b | output | OFS_W (8) | Almost-empty threshold, port-B side |
| ofs_af_a | output | OFS_W (8) | Almost-full threshold, port-A side |
| ofs_af_b | output | OFS_W (8) | Almost-full threshold, port-B side |
| a_in_rdy | output | 1 | Port-A input ready |
| b_in_rdy | output | 1 | Port-B input ready; high once loading has finished |

## Verification
The bench drives parallel writes whose data carries set upper bits. A design that took the wrong slice of the bus, or that advanced its register index on idle cycles, would leave wrong values in the offsets. Serial loads insert disabled cycles in which the data line still toggles. A design that shifted without the serial enable, or that shifted LSB first, would scramble the chain.

After each load finishes, further writes and shifts are applied, and they must leave both the offsets and the ready signals untouched. A second reset arrives in the middle of a parallel load and switches the mode to a preset. A design that kept its stale counter or its old mode would then report the wrong values or the wrong ready timing. Every preset code is also checked, and so is the timing of `a_in_rdy` in each mode.

// File: rtl/ofs_loader_pkg.sv
package ofs_loader_pkg;

    typedef enum logic [2:0] {
        MODE_PAR   = 3'd0,
        MODE_SER   = 3'd1,
        MODE_PRE8  = 3'd2,
        MODE_PRE16 = 3'd3,
        MODE_PRE64 = 3'd4
    } load_mode_e;

    function automatic logic is_preset(input load_mode_e m);
        return (m == MODE_PRE8) || (m == MODE_PRE16) || (m == MODE_PRE64);
    endfunction

    function automatic logic [15:0] preset_value(input load_mode_e m);
        case (m)
            MODE_PRE8:  return 16'd8;
            MODE_PRE16: return 16'd16;
            MODE_PRE64: return 16'd64;
            default:    return 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/ofs_mode_dec.sv
module ofs_mode_dec
    import ofs_loader_pkg::*;
(
    input  logic       pin_serial,
    input  logic       pin_hi,
    input  logic       pin_lo,
    output load_mode_e mode
);
    always_comb begin
        if (pin_serial) begin
            mode = MODE_SER;
        end else begin
            case ({pin_hi, pin_lo})
                2'b00:   mode = MODE_PAR;
                2'b01:   mode = MODE_PRE8;
                2'b10:   mode = MODE_PRE16;
                default: mode = MODE_PRE64;
            endcase
        end
    end
endmodule

// File: rtl/ofs_prog_ctr.sv
module ofs_prog_ctr #(
    parameter int LIMIT = 32,
    localparam int CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          at_last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && !at_last) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign cnt     = cnt_q;
    assign at_last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
    import ofs_loader_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int A_W   = 36,
    localparam int OFS_W = $clog2(DEPTH),
    localparam int CHAIN = 4 * OFS_W
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             cfg_serial,
    input  logic             cfg_sel_hi,
    input  logic             cfg_sel_lo,
    input  logic             a_wr,
    input  logic [A_W-1:0]   a_data,
    output logic [OFS_W-1:0] ofs_ae_a,
    output logic [OFS_W-1:0] ofs_ae_b,
    output logic [OFS_W-1:0] ofs_af_a,
    output logic [OFS_W-1:0] ofs_af_b,
    output logic             a_in_rdy,
    output logic             b_in_rdy
);
    localparam int CW = $clog2(CHAIN);

    typedef struct packed {
        load_mode_e       mode;
        logic [OFS_W-1:0] ae_a;
        logic [OFS_W-1:0] ae_b;
        logic [OFS_W-1:0] af_a;
        logic [OFS_W-1:0] af_b;
        logic             done;
        logic             rdy_a;
    } ld_state_t;

    ld_state_t st_d, st_q;

    load_mode_e       pin_mode;
    logic [CW-1:0]    step_cnt;
    logic             step_last;
    logic             step_inc;
    logic [OFS_W-1:0] pre_val;
    logic [OFS_W-1:0] par_val;

    ofs_mode_dec u_dec (
        .pin_serial (cfg_serial),
        .pin_hi     (cfg_sel_hi),
        .pin_lo     (cfg_sel_lo),
        .mode       (pin_mode)
    );

    ofs_prog_ctr #(.LIMIT(CHAIN)) u_ctr (
        .clk     (clk),
        .clr     (!mrst_n),
        .inc     (step_inc),
        .cnt     (step_cnt),
        .at_last (step_last)
    );

    assign pre_val = OFS_W'(preset_value(pin_mode));
    assign par_val = a_data[OFS_W-1:0];

    assign step_inc = mrst_n && !st_q.done &&
                      (((st_q.mode == MODE_PAR) && a_wr) ||
                       ((st_q.mode == MODE_SER) && cfg_sel_hi));

    always_comb begin
        st_d = st_q;
        if (!mrst_n) begin
            st_d.mode  = pin_mode;
            st_d.ae_a  = pre_val;
            st_d.ae_b  = pre_val;
            st_d.af_a  = pre_val;
            st_d.af_b  = pre_val;
            st_d.done  = 1'b0;
            st_d.rdy_a = 1'b0;
        end else begin
            if (!st_q.done) begin
                case (st_q.mode)
                    MODE_PAR: begin
                        if (a_wr) begin
                            case (step_cnt[1:0])
                                2'd0:    st_d.ae_a = par_val;
                                2'd1:    st_d.ae_b = par_val;
                                2'd2:    st_d.af_a = par_val;
                                default: st_d.af_b = par_val;
                            endcase
                            if (step_cnt == CW'(3)) st_d.done = 1'b1;
                        end
                    end
                    MODE_SER: begin
                        if (cfg_sel_hi) begin
                            {st_d.ae_a, st_d.ae_b, st_d.af_a, st_d.af_b} =
                                {st_q.ae_a, st_q.ae_b, st_q.af_a, st_q.af_b,
                                 cfg_sel_lo} >> 0;
                            if (step_last) st_d.done = 1'b1;
                        end
                    end
                    default: st_d.done = 1'b1;
                endcase
            end
            st_d.rdy_a = st_d.done || (st_q.mode == MODE_PAR);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ofs_ae_a = st_q.ae_a;
    assign ofs_ae_b = st_q.ae_b;
    assign ofs_af_a = st_q.af_a;
    assign ofs_af_b = st_q.af_b;
    assign a_in_rdy = st_q.rdy_a;
    assign b_in_rdy = st_q.done;
endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
    parameter int OFS_W = 8
) (
    input logic             clk,
    input logic             mrst_n,
    input logic [OFS_W-1:0] ofs_ae_a,
    input logic [OFS_W-1:0] ofs_ae_b,
    input logic [OFS_W-1:0] ofs_af_a,
    input logic [OFS_W-1:0] ofs_af_b,
    input logic             a_in_rdy,
    input logic             b_in_rdy,
    input logic             mode_ser,
    input logic             mode_pre
);
    // R1: a reset edge leaves both ready outputs low
    p_reset_clears_r1: assert property (@(posedge clk)
        !mrst_n |=> (!b_in_rdy && !a_in_rdy));

    // R3: a preset mode finishes one edge after reset release
    p_preset_done_r3: assert property (@(posedge clk) disable iff (!mrst_n)
        (mode_pre && !b_in_rdy) |=> b_in_rdy);

    // R7: serial loading keeps port A closed
    p_serial_closed_r7: assert property (@(posedge clk) disable iff (!mrst_n)
        (mode_ser && !b_in_rdy) |-> !a_in_rdy);

    // R7: finished loading opens port A
    p_done_opens_a_r7: assert property (@(posedge clk) disable iff (!mrst_n)
        b_in_rdy |-> a_in_rdy);

    // R8: ready to port B is sticky
    p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!mrst_n)
        b_in_rdy |=> b_in_rdy);

    // R8: thresholds frozen after loading
    p_offsets_frozen_r8: assert property (@(posedge clk) disable iff (!mrst_n)
        b_in_rdy |=> ($stable(ofs_ae_a) && $stable(ofs_ae_b) &&
                      $stable(ofs_af_a) && $stable(ofs_af_b)));
endmodule

bind ofs_loader ofs_loader_chk #(.OFS_W(OFS_W)) u_chk (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .ofs_ae_a (ofs_ae_a),
    .ofs_ae_b (ofs_ae_b),
    .ofs_af_a (ofs_af_a),
    .ofs_af_b (ofs_af_b),
    .a_in_rdy (a_in_rdy),
    .b_in_rdy (b_in_rdy),
    .mode_ser (st_q.mode == ofs_loader_pkg::MODE_SER),
    .mode_pre (ofs_loader_pkg::is_preset(st_q.mode))
);

// File: tb/sim_ofs_loader.sv
module sim_ofs_loader;
    localparam int CLK_P = 10;
    localparam int OFS_W = 8;
    localparam int A_W   = 36;
    localparam int CHAIN = 4 * OFS_W;

    typedef struct {
        string            tag;
        logic [CHAIN-1:0] offs;
        logic             a_rdy;
        logic             b_rdy;
    } exp_t;

    logic clk = 1'b0;
    logic mrst_n = 1'b0;
    logic cfg_serial = 1'b0, cfg_sel_hi = 1'b0, cfg_sel_lo = 1'b0;
    logic a_wr = 1'b0;
    logic [A_W-1:0] a_data = '0;
    logic [OFS_W-1:0] ofs_ae_a, ofs_ae_b, ofs_af_a, ofs_af_b;
    logic a_in_rdy, b_in_rdy;

    int n_checks = 0;
    int n_fail   = 0;
    exp_t sb[$];

    // bench model
    int               m_mode = 0;   // 0 par, 1 ser, 2 pre
    int               m_cnt  = 0;
    logic [CHAIN-1:0] m_offs = '0;
    logic             m_done = 1'b0;
    logic             m_a    = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ofs_loader #(.DEPTH(256), .A_W(A_W)) u0 (
        .clk(clk), .mrst_n(mrst_n), .cfg_serial(cfg_serial),
        .cfg_sel_hi(cfg_sel_hi), .cfg_sel_lo(cfg_sel_lo),
        .a_wr(a_wr), .a_data(a_data),
        .ofs_ae_a(ofs_ae_a), .ofs_ae_b(ofs_ae_b),
        .ofs_af_a(ofs_af_a), .ofs_af_b(ofs_af_b),
        .a_in_rdy(a_in_rdy), .b_in_rdy(b_in_rdy)
    );

    // monitor
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            logic [CHAIN-1:0] act;
            e = sb.pop_front();
            act = {ofs_ae_a, ofs_ae_b, ofs_af_a, ofs_af_b};
            n_checks++;
            if (act !== e.offs || a_in_rdy !== e.a_rdy || b_in_rdy !== e.b_rdy) begin
                n_fail++;
                $display("FIFO loader FAIL %s: got offs=%h a=%b b=%b expected offs=%h a=%b b=%b",
                         e.tag, act, a_in_rdy, b_in_rdy, e.offs, e.a_rdy, e.b_rdy);
            end
        end
    end

    task automatic push(input string tag);
        exp_t e;
        e.tag = tag; e.offs = m_offs; e.a_rdy = m_a; e.b_rdy = m_done;
        sb.push_back(e);
    endtask

    // one clock of stimulus; model updated after the edge
    task automatic tick(input logic rst_n, input logic ser, input logic hi,
                        input logic lo, input logic wr,
                        input logic [A_W-1:0] d, input string tag);
        @(negedge clk);
        mrst_n = rst_n; cfg_serial = ser; cfg_sel_hi = hi; cfg_sel_lo = lo;
        a_wr = wr; a_data = d;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            // R2 mode selection
            if (ser) m_mode = 1;
            else if ({hi, lo} == 2'b00) m_mode = 0;
            else m_mode = 2;
            case ({ser, hi, lo})
                3'b001:  m_offs = {4{8'd8}};
                3'b010:  m_offs = {4{8'd16}};
                3'b011:  m_offs = {4{8'd64}};
                default: m_offs = '0;
            endcase
            m_cnt = 0; m_done = 1'b0; m_a = 1'b0;
        end else begin
            if (!m_done) begin
                if (m_mode == 0 && wr) begin
                    m_offs[CHAIN-1-m_cnt*OFS_W -: OFS_W] = d[OFS_W-1:0];
                    m_cnt++;
                    if (m_cnt == 4) m_done = 1'b1;
                end else if (m_mode == 1 && hi) begin
                    m_offs = {m_offs[CHAIN-2:0], lo};
                    m_cnt++;
                    if (m_cnt == CHAIN) m_done = 1'b1;
                end else if (m_mode == 2) begin
                    m_done = 1'b1;
                end
            end
            m_a = m_done || (m_mode == 0);
        end
        push(tag);
    endtask

    task automatic do_reset(input logic ser, input logic hi, input logic lo,
                            input string tag);
        for (int i = 0; i < 2; i++) tick(1'b0, ser, hi, lo, 1'b0, '0, tag);
    endtask

    initial begin
        logic [CHAIN-1:0] pat;
        // R1 reset state, parallel mode
        do_reset(1'b0, 1'b0, 1'b0, "R1 reset parallel");
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R7 parallel opens A");
        // R4/R5 parallel writes with junk upper bits, idle gaps, pins toggling (R2 latched)
        tick(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 36'hABCDE_F003, "R4 write ae_a");
        tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 36'h000000077, "R5 idle no effect");
        tick(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 36'hF000000FC, "R4 write ae_b");
        tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 36'h123456701, "R4 write af_a");
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 36'h0000000AA, "R5 idle before last");
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 36'h800000180, "R5 fourth write done");
        for (int i = 0; i < 3; i++)
            tick(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 36'h0000000FF, "R8 frozen parallel");

        // R1 reset mid-load, then preset 16
        do_reset(1'b0, 1'b0, 1'b0, "R1 reset parallel again");
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 36'h5, "R4 partial write");
        do_reset(1'b0, 1'b1, 1'b0, "R1 reset mid-load preset16");
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 36'h9, "R3 preset16 ready");
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 36'h9, "R8 preset16 frozen");

        // R3 other presets
        do_reset(1'b0, 1'b0, 1'b1, "R1 reset preset8");
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3 preset8 ready");
        do_reset(1'b0, 1'b1, 1'b1, "R1 reset preset64");
        tick(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R3 preset64 ready");

        // R6 serial load: values 5,200,17,252
        pat = 32'h05C811FC;
        do_reset(1'b1, 1'b0, 1'b0, "R1 reset serial");
        for (int b = CHAIN - 1; b >= 0; b--) begin
            if (b % 3 == 0)
                tick(1'b1, 1'b0, 1'b0, ~pat[b], 1'b1, 36'hFF, "R6 serial idle R7 A closed");
            tick(1'b1, 1'b0, 1'b1, pat[b], 1'b1, 36'hFF, "R6 serial shift");
        end
        for (int i = 0; i < 3; i++)
            tick(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 36'h33, "R8 frozen serial");

        wait (sb.size() == 0);
        @(negedge clk);
        if (m_offs !== 32'h05C811FC) begin
            n_fail++;
            $display("FAIL R6 model chain %h expected %h", m_offs, 32'h05C811FC);
        end
        n_checks++;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule